// File: doc/BRIEF.md
# ADC Bus Register Interface

This block is a classic-cycle Wishbone slave that sits between a processor bus and a successive-approximation converter controller. Software uses it to drive the controller's start, converter-enable and reference-buffer-enable lines and to program the sample window length. It also reads back the end-of-conversion flag and the 12-bit conversion result.

There are four 32-bit word registers. Only the low address bits are decoded, relative to the block's base. Every request is acknowledged in a single cycle, and this includes requests to holes in the map. Read data is sampled on the same clock edge that raises the acknowledge. Writes honour the byte-lane selects.

The controller starts a conversion on a rising edge of its start input. The start bit is a plain stored level, so software launches a new conversion by writing the bit low and then high again.

Top module: `adc_wb_regif`

## Requirements
- R1: While `rst_i` is high and after it falls, `soc_o`, `adc_en_o` and `amp_en_o` are 0, `swidth_o` is 4 and `ack_o` is 0.
- R2: `ack_o` goes high in the cycle after the first edge at which `cyc_i` and `stb_i` are both high, and it stays high for exactly one cycle.
- R3: The control word sits at offset 0x0. Bit 0 drives `soc_o`, bit 1 drives `adc_en_o` and bit 2 drives `amp_en_o`. It can be read back, and bits 31:3 read as 0.
- R4: The status word sits at offset 0x4. Bit 1 returns `eoc_i` and every other bit reads 0. Writes to it change no register.
- R5: The result word sits at offset 0x8. Bits 11:0 return `result_i` and bits 31:12 read 0. Writes to it change no register.
- R6: The configuration word sits at offset 0xC. Bits 3:0 drive `swidth_o` and can be read back. Bits 31:4 read 0.
- R7: A write changes a byte lane only when that lane's `sel_i` bit is set. Every implemented field lies in lane 0, which is controlled by `sel_i[0]`.
- R8: An offset that is not word aligned, or that lies in 0x10 to 0x1C, is acknowledged, reads 0 and ignores writes.
- R9: Only `adr_i[4:0]` is decoded. An address of 0x20 reaches the control word and 0x2C reaches the configuration word.
- R10: The start bit holds its written value. Writing 1 while it is already 1 keeps `soc_o` high, and a new rising edge needs a write of 0 and then a write of 1.
- R11: Register outputs change on the edge that raises `ack_o`. Read data is the value present at that edge and holds while `ack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| adr_i | input | 32 | Byte address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| sel_i | input | 4 | Byte-lane selects |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Strobe |
| we_i | input | 1 | Write enable |
| ack_o | output | 1 | Single-cycle acknowledge |
| soc_o | output | 1 | Start-of-conversion level to the controller |
| adc_en_o | output | 1 | Converter enable |
| amp_en_o | output | 1 | Reference buffer enable |
| swidth_o | output | 4 | Sample window in clock cycles |
| eoc_i | input | 1 | End-of-conversion from the controller |
| result_i | input | 12 | Conversion result |

## Verification
A wrong register state is visible on the converter-side outputs one cycle after the write that set it. It is also visible on `dat_o` during the acknowledge of the next read, so the bench reads each word back after every write. A fault in address decoding or lane masking shows up as a changed control or configuration field after a write that should have been dropped. A fault in the acknowledge logic shows as a missing or doubled `ack_o` at the negative edge straight after the request edge.

// File: rtl/adc_wb_pkg.sv
package adc_wb_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned LANES    = DW / 8;
  localparam int unsigned RES_W    = 12;
  localparam int unsigned SW_W     = 4;
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_DATA = 2;
  localparam int unsigned IDX_CFG  = 3;
  localparam logic [DW-1:0] CTRL_MASK = 32'h0000_0007;
  localparam logic [DW-1:0] CFG_MASK  = 32'h0000_000F;
  localparam logic [DW-1:0] CFG_RST   = 32'h0000_0004;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_STAT, SEL_DATA, SEL_CFG, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/adc_wb_ack.sv
module adc_wb_ack (
  input  logic clk_i,
  input  logic rst_i,
  input  logic cyc_i,
  input  logic stb_i,
  output logic take_o,
  output logic ack_o
);
  logic ack_q;

  // one acknowledge per request: a request seen while ack is high is the same one
  assign take_o = cyc_i & stb_i & ~ack_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) ack_q <= 1'b0;
    else       ack_q <= take_o;
  end

  assign ack_o = ack_q;
endmodule

// File: rtl/adc_wb_wreg.sv
module adc_wb_wreg #(
  parameter int unsigned    DW    = 32,
  parameter logic [DW-1:0]  MASK  = '1,
  parameter logic [DW-1:0]  RST   = '0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            wr_i,
  input  logic [DW/8-1:0] sel_i,
  input  logic [DW-1:0]   dat_i,
  output logic [DW-1:0]   q_o
);
  localparam int unsigned LANES = DW / 8;
  logic [DW-1:0] q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)                 q[l*8 +: 8] <= RST[l*8 +: 8] & MASK[l*8 +: 8];
      else if (wr_i && sel_i[l]) q[l*8 +: 8] <= dat_i[l*8 +: 8] & MASK[l*8 +: 8];
    end
  end

  assign q_o = q;
endmodule

// File: rtl/adc_wb_rdmux.sv
module adc_wb_rdmux
  import adc_wb_pkg::*;
(
  input  reg_sel_e          sel_i,
  input  logic [DW-1:0]     ctrl_i,
  input  logic [DW-1:0]     cfg_i,
  input  logic              eoc_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_CTRL: rdata_o = ctrl_i;
      SEL_STAT: rdata_o[1] = eoc_i;
      SEL_DATA: rdata_o[RES_W-1:0] = result_i;
      SEL_CFG:  rdata_o = cfg_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adc_wb_regif.sv
module adc_wb_regif
  import adc_wb_pkg::*;
#(
  parameter int unsigned ADR_BITS = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [31:0]       adr_i,
  input  logic [31:0]       dat_i,
  output logic [31:0]       dat_o,
  input  logic [3:0]        sel_i,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  output logic              ack_o,
  output logic              soc_o,
  output logic              adc_en_o,
  output logic              amp_en_o,
  output logic [SW_W-1:0]   swidth_o,
  input  logic              eoc_i,
  input  logic [RES_W-1:0]  result_i
);
  localparam int unsigned IDX_W = ADR_BITS - 2;

  logic            take;
  logic [IDX_W-1:0] idx;
  reg_sel_e        rsel;
  logic [DW-1:0]   ctrl_q, cfg_q, rdata, dat_q;

  adc_wb_ack u_ack (
    .clk_i(clk_i), .rst_i(rst_i), .cyc_i(cyc_i), .stb_i(stb_i),
    .take_o(take), .ack_o(ack_o)
  );

  // low-bit decode only; unaligned or beyond the four words is a hole
  assign idx = adr_i[ADR_BITS-1:2];
  always_comb begin
    rsel = SEL_NONE;
    if (adr_i[1:0] == 2'b00) begin
      if      (idx == IDX_W'(IDX_CTRL)) rsel = SEL_CTRL;
      else if (idx == IDX_W'(IDX_STAT)) rsel = SEL_STAT;
      else if (idx == IDX_W'(IDX_DATA)) rsel = SEL_DATA;
      else if (idx == IDX_W'(IDX_CFG))  rsel = SEL_CFG;
    end
  end

  adc_wb_wreg #(.DW(DW), .MASK(CTRL_MASK), .RST('0)) u_ctrl (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_i(take && we_i && rsel == SEL_CTRL),
    .sel_i(sel_i), .dat_i(dat_i), .q_o(ctrl_q)
  );

  adc_wb_wreg #(.DW(DW), .MASK(CFG_MASK), .RST(CFG_RST)) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_i(take && we_i && rsel == SEL_CFG),
    .sel_i(sel_i), .dat_i(dat_i), .q_o(cfg_q)
  );

  adc_wb_rdmux u_rdmux (
    .sel_i(rsel), .ctrl_i(ctrl_q), .cfg_i(cfg_q),
    .eoc_i(eoc_i), .result_i(result_i), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)              dat_q <= '0;
    else if (take && !we_i) dat_q <= rdata;
    else                    dat_q <= '0;
  end

  assign dat_o    = dat_q;
  assign soc_o    = ctrl_q[0];
  assign adc_en_o = ctrl_q[1];
  assign amp_en_o = ctrl_q[2];
  assign swidth_o = cfg_q[SW_W-1:0];
endmodule

// File: rtl/adc_wb_regif_chk.sv
module adc_wb_regif_chk #(
  parameter int unsigned ADR_BITS = 5
) (
  input logic        clk_i,
  input logic        rst_i,
  input logic [31:0] adr_i,
  input logic [31:0] dat_o,
  input logic [3:0]  sel_i,
  input logic        cyc_i,
  input logic        stb_i,
  input logic        we_i,
  input logic        ack_o,
  input logic        adc_en_o,
  input logic [3:0]  swidth_o,
  input logic        eoc_i,
  input logic [11:0] result_i
);
  assert_ack_single_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |=> !ack_o);

  assert_ack_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_o |-> $past(cyc_i && stb_i));

  assert_ctrl_upper_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(we_i) && $past(adr_i[ADR_BITS-1:0]) == '0) |-> dat_o[31:3] == '0);

  assert_status_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(we_i) && $past(adr_i[ADR_BITS-1:0]) == ADR_BITS'(4))
      |-> dat_o == {30'b0, $past(eoc_i), 1'b0});

  assert_result_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(we_i) && $past(adr_i[ADR_BITS-1:0]) == ADR_BITS'(8))
      |-> dat_o == {20'b0, $past(result_i)});

  assert_lane_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(sel_i[0])) |-> ($stable(swidth_o) && $stable(adc_en_o)));

  assert_hole_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_o && !$past(we_i) && $past(adr_i[1:0]) != 2'b00) |-> dat_o == '0);
endmodule

bind adc_wb_regif adc_wb_regif_chk #(.ADR_BITS(ADR_BITS)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .adr_i(adr_i), .dat_o(dat_o), .sel_i(sel_i),
  .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i), .ack_o(ack_o),
  .adc_en_o(adc_en_o), .swidth_o(swidth_o), .eoc_i(eoc_i), .result_i(result_i)
);

// File: tb/tb_adc_wb_regif.sv
module tb_adc_wb_regif;
  logic        clk_i = 0, rst_i = 1;
  logic [31:0] adr_i = 0, dat_i = 0, dat_o;
  logic [3:0]  sel_i = 0;
  logic        cyc_i = 0, stb_i = 0, we_i = 0, ack_o;
  logic        soc_o, adc_en_o, amp_en_o, eoc_i = 0;
  logic [3:0]  swidth_o;
  logic [11:0] result_i = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  adc_wb_regif dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] adr, input logic [31:0] dat,
                        input logic [3:0] sel, output logic [31:0] rd);
    @(negedge clk_i);
    cyc_i = 1; stb_i = 1; we_i = we; adr_i = adr; dat_i = dat; sel_i = sel;
    check("R2 no early ack", {31'b0, ack_o}, 32'd0);
    @(negedge clk_i);
    check("R2 ack", {31'b0, ack_o}, 32'd1);
    rd = dat_o;
    cyc_i = 0; stb_i = 0; we_i = 0;
    @(negedge clk_i);
    check("R2 ack one cycle", {31'b0, ack_o}, 32'd0);
  endtask

  task automatic wr(input logic [31:0] adr, input logic [31:0] dat, input logic [3:0] sel = 4'hF);
    logic [31:0] d;
    access(1'b1, adr, dat, sel, d);
  endtask

  task automatic rd_chk(string req, input logic [31:0] adr, input logic [31:0] exp);
    logic [31:0] d;
    access(1'b0, adr, 32'h0, 4'hF, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R1 soc", {31'b0, soc_o}, 0);
    check("R1 en", {31'b0, adc_en_o}, 0);
    check("R1 amp", {31'b0, amp_en_o}, 0);
    check("R1 swidth", {28'b0, swidth_o}, 4);
    check("R1 ack", {31'b0, ack_o}, 0);
    rd_chk("R1 cfg readback", 32'hC, 32'h4);
  endtask

  task automatic t_ctrl();
    wr(32'h0, 32'h6);
    check("R3 soc", {31'b0, soc_o}, 0);
    check("R3 en", {31'b0, adc_en_o}, 1);
    check("R3 amp", {31'b0, amp_en_o}, 1);
    wr(32'h0, 32'hFFFF_FFFF);
    rd_chk("R3 upper zero", 32'h0, 32'h7);
    wr(32'h0, 32'h0);
    rd_chk("R3 clear", 32'h0, 32'h0);
  endtask

  task automatic t_status();
    eoc_i = 1;
    rd_chk("R4 eoc set", 32'h4, 32'h2);
    eoc_i = 0;
    rd_chk("R4 eoc clear", 32'h4, 32'h0);
    wr(32'h0, 32'h2);
    wr(32'h4, 32'hFFFF_FFFF);
    rd_chk("R4 write ignored ctrl", 32'h0, 32'h2);
    rd_chk("R4 write ignored cfg", 32'hC, 32'h4);
  endtask

  task automatic t_data();
    result_i = 12'hABC;
    rd_chk("R5 result", 32'h8, 32'hABC);
    result_i = 12'hFFF;
    rd_chk("R5 full scale", 32'h8, 32'hFFF);
    wr(32'h8, 32'h0);
    rd_chk("R5 write ignored", 32'h8, 32'hFFF);
    rd_chk("R5 write ignored ctrl", 32'h0, 32'h2);
  endtask

  task automatic t_cfg();
    wr(32'hC, 32'h9);
    check("R6 swidth", {28'b0, swidth_o}, 9);
    wr(32'hC, 32'hFFFF_FFF0);
    check("R6 swidth zero", {28'b0, swidth_o}, 0);
    rd_chk("R6 readback", 32'hC, 32'h0);
    wr(32'hC, 32'hFFFF_FFFF);
    rd_chk("R6 upper zero", 32'hC, 32'hF);
  endtask

  task automatic t_lanes();
    wr(32'h0, 32'h7);
    wr(32'h0, 32'h0, 4'b1110);
    rd_chk("R7 lane0 masked ctrl", 32'h0, 32'h7);
    wr(32'hC, 32'h3, 4'b1110);
    check("R7 lane0 masked cfg", {28'b0, swidth_o}, 4'hF);
    wr(32'hC, 32'h3, 4'b0001);
    check("R7 lane0 write", {28'b0, swidth_o}, 3);
  endtask

  task automatic t_holes();
    rd_chk("R8 hole 0x10", 32'h10, 32'h0);
    rd_chk("R8 hole 0x1C", 32'h1C, 32'h0);
    rd_chk("R8 unaligned", 32'h2, 32'h0);
    wr(32'h14, 32'hFFFF_FFFF);
    wr(32'h1, 32'h0);
    rd_chk("R8 write ignored ctrl", 32'h0, 32'h7);
    check("R8 write ignored cfg", {28'b0, swidth_o}, 3);
  endtask

  task automatic t_alias();
    wr(32'h20, 32'h2);
    check("R9 alias ctrl en", {31'b0, adc_en_o}, 1);
    check("R9 alias ctrl soc", {31'b0, soc_o}, 0);
    wr(32'hFFFF_FFEC, 32'h5);
    rd_chk("R9 alias cfg", 32'h2C, 32'h5);
  endtask

  task automatic t_start();
    logic [31:0] d;
    wr(32'h0, 32'h1);
    check("R10 soc set", {31'b0, soc_o}, 1);
    @(negedge clk_i);
    cyc_i = 1; stb_i = 1; we_i = 1; adr_i = 0; dat_i = 1; sel_i = 4'hF;
    @(posedge clk_i); #2;
    check("R10 soc held", {31'b0, soc_o}, 1);
    @(negedge clk_i); cyc_i = 0; stb_i = 0; we_i = 0;
    wr(32'h0, 32'h0);
    check("R10 soc cleared", {31'b0, soc_o}, 0);
    @(negedge clk_i);
    cyc_i = 1; stb_i = 1; we_i = 1; dat_i = 1;
    @(posedge clk_i); #2;
    check("R11 soc on ack edge", {31'b0, soc_o}, 1);
    check("R11 ack with soc", {31'b0, ack_o}, 1);
    @(negedge clk_i); cyc_i = 0; stb_i = 0; we_i = 0;
    @(negedge clk_i);
    result_i = 12'h123;
    cyc_i = 1; stb_i = 1; adr_i = 32'h8;
    @(posedge clk_i); #2;
    result_i = 12'h456;
    @(negedge clk_i);
    check("R11 read captured", dat_o, 32'h123);
    d = dat_o;
    cyc_i = 0; stb_i = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 in reset", {27'b0, swidth_o, soc_o}, {27'b0, 4'd4, 1'b0});
    rst_i = 0;
    t_reset();
    t_ctrl();
    t_status();
    t_data();
    t_cfg();
    t_lanes();
    t_holes();
    t_alias();
    t_start();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule